// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A behavioural, synthesizable model of a pipelined synchronous static RAM with an 18-bit word made of two 9-bit lanes. Address and command are registered on the rising clock edge. A read drives its data in the cycle after it is issued. A write takes its data from the bus in the cycle after its address and command, which is the late-write scheme. Each lane has its own active-low write select, so one command can update one lane or both.

Captured write data waits in a pending-write register and moves into the array when the next write's data arrives. A read that hits the pending entry, or the write whose data is arriving on the same edge, sees the newest data, merged lane by lane over the stored word. The bidirectional bus is split into data-in, data-out and a drive-enable. Drive is gated at once by an active-low output enable and by a sleep input. The depth is a parameter so that simulation stays small.

Top module: `lw_sram_core`

## Requirements
- R1: Lane a is bits 8:0 and is written when `lane_wr_n[0]` is 0. Lane b is bits 17:9 and is written when `lane_wr_n[1]` is 0. A lane whose select is 1 keeps its stored value.
- R2: A read (`sel_n`=0, `wr_n`=1, `sleep`=0 at an edge) returns the word at `addr` on `dq_out` during the next cycle. `dq_oe` is 1 in that cycle when `oe_n` is 0 and `sleep` is 0.
- R3: A write (`sel_n`=0, `wr_n`=0, `sleep`=0 at an edge) takes its data from `dq_in` at the following rising edge.
- R4: A read to an address whose write is still pending, including a read issued on the edge where that write's data arrives, returns the newest data lane by lane.
- R5: With `sel_n`=1 at an edge, no operation is started and `dq_oe` is 0 in the next cycle.
- R6: While `sleep` is 1, `dq_oe` is 0. It also stays 0 for the cycle after an edge at which `sleep` was 1. A command presented at such an edge is ignored.
- R7: `oe_n`=1 forces `dq_oe` to 0 without waiting for a clock edge. A read issued under it is a dummy read that changes no stored data.
- R8: `dq_oe` is 0 in the cycle after a write command.
- R9: During reset (`rst_n`=0, synchronous) and in the cycle after it, `dq_oe` is 0.
- R10: Back-to-back writes lose no data. Every word written reads back unchanged later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write command |
| lane_wr_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep, forces the bus off |
| dq_in | input | W | Data from the bus (write data) |
| dq_out | output | W | Data to the bus (read data) |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that every input has a known level at each rising edge once reset is released. They also assume that `oe_n` and `sleep` change only between edges, so that the value sampled at an edge matches the value the drive gate saw. The bench changes every input on the falling edge and holds it through the next rising edge. It draws addresses only from a set it has preloaded, so no read returns an unknown word. Sleep, deselect and output-enable pulses are mixed freely with reads and writes, including sleep on the cycle that carries late write data.

// File: rtl/lw_sram_pkg.sv
// Package: shared types of the late-write SRAM core.
// Assumes: nothing beyond IEEE 1800-2017.
package lw_sram_pkg;
    // Operation started at a rising edge.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } lw_op_e;
endpackage

// File: rtl/lw_sram_decode.sv
// Module: lw_sram_decode
// Turns select, write enable and sleep into the operation for this edge, and
// turns the active-low lane selects into active-high lane enables.
// Assumes: inputs are stable around the rising edge; purely combinational.
module lw_sram_decode #(
    parameter int LANES = 2
) (
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic             sleep,
    input  logic [LANES-1:0] lane_wr_n,
    output lw_sram_pkg::lw_op_e op,
    output logic [LANES-1:0] lane_en
);
    import lw_sram_pkg::*;

    // Decide the operation: sleep and deselect both block it.
    always_comb begin
        if (sleep || sel_n) op = OP_IDLE;
        else if (wr_n)      op = OP_READ;
        else                op = OP_WRITE;
    end

    // Lane enables are the inverse of the active-low selects.
    assign lane_en = ~lane_wr_n;
endmodule

// File: rtl/lw_sram_array.sv
// Module: lw_sram_array
// Word storage with one lane-masked write port and one combinational read port.
// Assumes: at most one write per edge; contents are not reset.
module lw_sram_array #(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wlanes,
    input  logic [W-1:0]     wdata,
    input  logic [AW-1:0]    raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [DEPTH];

    // Write only the enabled lanes of the addressed word.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we && wlanes[l]) begin
                mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // Read the stored word without delay.
    assign rdata = mem[raddr];
endmodule

// File: rtl/lw_sram_wbuf.sv
// Module: lw_sram_wbuf
// Late-write path. It holds the address stage of a write, captures the data a
// cycle later into a pending register, retires the older pending entry to the
// array when new data arrives, and merges pending and arriving data over the
// array word for reads.
// Assumes: the array accepts one write per edge; synchronous active-low reset.
module lw_sram_wbuf #(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_issue,
    input  logic [AW-1:0]    issue_addr,
    input  logic [LANES-1:0] issue_lanes,
    input  logic [W-1:0]     dq_in,
    input  logic [AW-1:0]    rd_addr,
    input  logic [W-1:0]     arr_rdata,
    output logic             commit_we,
    output logic [AW-1:0]    commit_addr,
    output logic [LANES-1:0] commit_lanes,
    output logic [W-1:0]     commit_data,
    output logic [W-1:0]     rd_merged
);
    logic             cmd_valid;
    logic [AW-1:0]    cmd_addr;
    logic [LANES-1:0] cmd_lanes;
    logic             pend_valid;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_lanes;
    logic [W-1:0]     pend_data;

    // Address stage: remember a write command until its data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_lanes <= '0;
        end else begin
            cmd_valid <= wr_issue;
            cmd_addr  <= issue_addr;
            cmd_lanes <= issue_lanes;
        end
    end

    // Data stage: capture arriving write data as the new pending entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_lanes <= '0;
            pend_data  <= '0;
        end else if (cmd_valid) begin
            pend_valid <= 1'b1;
            pend_addr  <= cmd_addr;
            pend_lanes <= cmd_lanes;
            pend_data  <= dq_in;
        end
    end

    // The old pending entry retires on the edge that loads a new one.
    assign commit_we    = cmd_valid && pend_valid;
    assign commit_addr  = pend_addr;
    assign commit_lanes = pend_lanes;
    assign commit_data  = pend_data;

    // Per-lane bypass: arriving data wins over pending, pending over array.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_val;
        always_comb begin
            lane_val = arr_rdata[l*LANE_W +: LANE_W];
            if (pend_valid && pend_addr == rd_addr && pend_lanes[l])
                lane_val = pend_data[l*LANE_W +: LANE_W];
            if (cmd_valid && cmd_addr == rd_addr && cmd_lanes[l])
                lane_val = dq_in[l*LANE_W +: LANE_W];
        end
        assign rd_merged[l*LANE_W +: LANE_W] = lane_val;
    end
endmodule

// File: rtl/lw_sram_outctl.sv
// Module: lw_sram_outctl
// Output register for read data and the bus drive gate. Drive needs a read
// issued at the last edge, output enable low, and sleep low now and at that edge.
// Assumes: oe_n and sleep act without a clock; synchronous active-low reset.
module lw_sram_outctl #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_issue,
    input  logic [W-1:0] rd_data,
    input  logic         sleep,
    input  logic         oe_n,
    output logic [W-1:0] dq_out,
    output logic         dq_oe
);
    logic         rd_valid_q;
    logic         sleep_q;
    logic [W-1:0] rd_data_q;

    // Mark whether the last edge started a read, and whether sleep was high then.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            sleep_q    <= 1'b0;
        end else begin
            rd_valid_q <= rd_issue;
            sleep_q    <= sleep;
        end
    end

    // Hold the read word for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_data_q <= '0;
        else if (rd_issue) rd_data_q <= rd_data;
    end

    assign dq_out = rd_data_q;
    assign dq_oe  = rd_valid_q && !oe_n && !sleep && !sleep_q;
endmodule

// File: rtl/lw_sram_core.sv
// Module: lw_sram_core (top)
// Pipelined synchronous SRAM with late write and per-lane write selects.
// Assumes: commands are sampled at the rising edge; oe_n and sleep gate the
// bus at once; the storage itself is not cleared by reset.
module lw_sram_core #(
    parameter int DEPTH  = 1024,
    parameter int LANE_W = 9,
    parameter int LANES  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int W     = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic [W-1:0]     dq_in,
    output logic [W-1:0]     dq_out,
    output logic             dq_oe
);
    import lw_sram_pkg::*;

    lw_op_e           op;
    logic [LANES-1:0] lane_en;
    logic             commit_we;
    logic [AW-1:0]    commit_addr;
    logic [LANES-1:0] commit_lanes;
    logic [W-1:0]     commit_data;
    logic [W-1:0]     arr_rdata;
    logic [W-1:0]     rd_merged;
    logic             rd_issue;
    logic             wr_issue;

    lw_sram_decode #(.LANES(LANES)) i_decode (
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .sleep     (sleep),
        .lane_wr_n (lane_wr_n),
        .op        (op),
        .lane_en   (lane_en)
    );

    assign rd_issue = (op == OP_READ);
    assign wr_issue = (op == OP_WRITE);

    lw_sram_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) i_array (
        .clk    (clk),
        .we     (commit_we),
        .waddr  (commit_addr),
        .wlanes (commit_lanes),
        .wdata  (commit_data),
        .raddr  (addr),
        .rdata  (arr_rdata)
    );

    lw_sram_wbuf #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) i_wbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_issue     (wr_issue),
        .issue_addr   (addr),
        .issue_lanes  (lane_en),
        .dq_in        (dq_in),
        .rd_addr      (addr),
        .arr_rdata    (arr_rdata),
        .commit_we    (commit_we),
        .commit_addr  (commit_addr),
        .commit_lanes (commit_lanes),
        .commit_data  (commit_data),
        .rd_merged    (rd_merged)
    );

    lw_sram_outctl #(.W(W)) i_outctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .rd_data  (rd_merged),
        .sleep    (sleep),
        .oe_n     (oe_n),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );
endmodule

// File: rtl/lw_sram_chk.sv
// Module: lw_sram_chk
// Protocol checks on the top-level ports of lw_sram_core, attached by bind.
// Assumes: inputs are known at every edge after reset.
module lw_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_n,
    input logic wr_n,
    input logic oe_n,
    input logic sleep,
    input logic dq_oe
);
    // R6
    sleep_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);
    // R6
    sleep_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !dq_oe);
    // R5
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !dq_oe);
    // R8
    write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !wr_n) |=> !dq_oe);
    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);
    // R2
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_n && wr_n && !sleep) && !oe_n && !sleep) |-> dq_oe);
    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !dq_oe);
endmodule

bind lw_sram_core lw_sram_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .oe_n  (oe_n),
    .sleep (sleep),
    .dq_oe (dq_oe)
);

// File: tb/test_lw_sram_core.sv
// Bench for lw_sram_core: a behavioural model (plain array, flags) advanced
// at every rising edge and compared with the ports in every cycle.
module test_lw_sram_core;
    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);
    localparam int W     = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [W-1:0]  dq_in = '0;
    logic [W-1:0]  dq_out;
    logic          dq_oe;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [W-1:0] ref_mem [DEPTH];
    bit           exp_rd = 1'b0;
    logic [W-1:0] exp_data = '0;
    bit           slept_at_edge = 1'b0;
    bit           pend_wr = 1'b0;
    int           pend_addr = 0;
    logic [1:0]   pend_ln = 2'b11;

    always #5 clk = ~clk;

    lw_sram_core #(.DEPTH(DEPTH)) i_lw_sram_core (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // One cycle: drive at the falling edge, check the current cycle, advance the model.
    task automatic step(input bit s_n, input bit w_n, input logic [1:0] ln,
                        input int a, input bit oe, input bit slp,
                        input logic [W-1:0] din, input string tag);
        bit exp_oe;
        @(negedge clk);
        sel_n = s_n; wr_n = w_n; lane_wr_n = ln; addr = AW'(a);
        oe_n = oe; sleep = slp; dq_in = din;
        #1;
        exp_oe = exp_rd && !oe && !slp && !slept_at_edge;
        vectors++;
        if (dq_oe !== exp_oe) begin
            misses++;
            $display("FAIL %s: dq_oe=%0b expected %0b", tag, dq_oe, exp_oe);
        end else if (exp_oe && dq_out !== exp_data) begin
            misses++;
            $display("FAIL %s: dq_out=%h expected %h", tag, dq_out, exp_data);
        end
        @(posedge clk);
        if (pend_wr) begin
            if (!pend_ln[0]) ref_mem[pend_addr][8:0]  = din[8:0];
            if (!pend_ln[1]) ref_mem[pend_addr][17:9] = din[17:9];
        end
        slept_at_edge = slp;
        exp_rd  = !slp && !s_n && w_n;
        pend_wr = !slp && !s_n && !w_n;
        if (exp_rd) exp_data = ref_mem[a];
        pend_addr = a;
        pend_ln   = ln;
    endtask

    function automatic int pick_addr(input int r);
        return (r % 17 == 16) ? DEPTH - 1 : r % 17;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1ms;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not end, expected end before timeout");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R9: bus quiet during reset and in the first cycle after it.
        repeat (3) begin
            @(negedge clk); #1;
            vectors++;
            if (dq_oe !== 1'b0) begin
                misses++;
                $display("FAIL R9 reset: dq_oe=%0b expected 0", dq_oe);
            end
        end
        @(negedge clk); rst_n = 1'b1;

        // R10, R3: back-to-back preload of addresses 0..15 and the top word.
        step(1, 1, 2'b11, 0, 0, 0, '0, "R9 after reset");
        for (int i = 0; i < 17; i++)
            step(0, 0, 2'b00, pick_addr(i), 0, 0, (i == 0) ? '0 : W'(18'h1000 + pick_addr(i - 1) * 37),
                 "R10 preload");
        step(1, 1, 2'b11, 0, 0, 0, W'(18'h1000 + (DEPTH - 1) * 37), "R3 last data");

        // R2, R10: read every preloaded word back to back.
        for (int i = 0; i < 17; i++)
            step(0, 1, 2'b11, pick_addr(i), 0, 0, '0, "R2 readback");

        // R4, R8: write then read the same address on the very next edge.
        step(0, 0, 2'b00, 5, 0, 0, '0, "R8 write cmd");
        step(0, 1, 2'b11, 5, 0, 0, 18'h2AB55, "R4 read on data edge");
        step(0, 1, 2'b11, 5, 0, 0, '0, "R4 read pending");

        // R1: lane a only, then lane b only, then none; read while pending.
        step(0, 0, 2'b10, 6, 0, 0, '0, "R1 lane a cmd");
        step(0, 0, 2'b01, 7, 0, 0, 18'h3FFFF, "R1 lane b cmd");
        step(0, 0, 2'b11, 6, 0, 0, 18'h00000, "R1 no lane cmd");
        step(0, 1, 2'b11, 6, 0, 0, 18'h15555, "R1 read lane a");
        step(0, 1, 2'b11, 7, 0, 0, '0, "R1 read lane b");

        // R5: deselect; R7: dummy read then async oe release mid-stream.
        step(1, 0, 2'b00, 6, 0, 0, '0, "R5 deselect");
        step(0, 1, 2'b11, 6, 1, 0, '0, "R5 quiet");
        step(0, 1, 2'b11, 6, 1, 0, '0, "R7 dummy read");
        step(0, 1, 2'b11, 7, 0, 0, '0, "R7 oe released");

        // R6: sleep blocks a write and a read; bus stays off the cycle after.
        step(0, 0, 2'b00, 3, 0, 1, '0, "R6 sleep write");
        step(0, 1, 2'b11, 3, 0, 0, 18'h12345, "R6 after sleep");
        step(0, 1, 2'b11, 3, 0, 1, '0, "R6 sleep read");
        step(1, 1, 2'b11, 3, 0, 0, '0, "R6 next cycle");

        // Mixed traffic covering all requirements (R1..R10).
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            step((r % 8) == 0, (r % 3) != 0, 2'($urandom_range(0, 3)),
                 pick_addr(int'($urandom_range(0, 16))), (r % 9) == 0,
                 (r % 16) == 1, W'($urandom), "R4 mixed");
        end
        step(1, 1, 2'b11, 0, 0, 0, W'($urandom), "R10 drain");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule